// File: doc/BRIEF.md
# Ethernet Port Status LED Driver

This block turns the status of a 10/100 Ethernet port into three active-high LED drives. It takes level inputs for link, speed and duplex, and single-cycle strobes for each transmitted frame, each received frame and each collision. One LED stays on while the link is up at the lower speed. A second LED blinks while frames move in either direction. The third LED stays on in full-duplex operation and switches to a faster blink while collisions occur. The collision blink takes precedence over the steady duplex indication.

All blinking comes from one free-running prescaler that divides the system clock into 25 ms ticks. The system clock frequency is given by the parameter `CLK_HZ`. Each strobe restarts a hold timer of one tenth of a second for its indication, and the indication blinks until that timer runs out. When a burst begins on an idle indication, its blink starts in the lit half. When the link goes down, every LED goes dark, both hold timers are cleared, and strobes are ignored until the link returns.

Top module: `ethLedDriver`

## Requirements
- R1: `ledLinkSpd` is high exactly while `linkUp` is high and `speed100` is low (0 = 10 Mbit/s, 1 = 100 Mbit/s). It follows those levels in the same cycle.
- R2: When the activity indication is idle, a `txPulse` or `rxPulse` sampled at a rising clock edge, with the link up and no `colPulse` in that cycle, makes `ledAct` high from that edge onward. A new burst always starts in the lit phase.
- R3: While the activity hold is running, `ledAct` blinks with a period of `CLK_HZ/10` cycles (10 Hz) and a 50% duty cycle, so it is high for `CLK_HZ/20` cycles in each period.
- R4: Each accepted transmit or receive strobe reloads the activity hold to `CLK_HZ/10` cycles. `ledAct` is low from the edge at which the hold reaches zero, which is `CLK_HZ/10` edges after the last accepted strobe.
- R5: A collision strobe never lights `ledAct`. A transmit or receive strobe that arrives in the same cycle as `colPulse` is not accepted as activity.
- R6: While the link is up, `fullDuplex` is high and no collision hold is running, `ledDupCol` is steadily high. With `fullDuplex` low and no collision hold running, it is low.
- R7: A `colPulse` with the link up reloads a collision hold of `CLK_HZ/10` cycles. While that hold runs, `ledDupCol` blinks with a period of `CLK_HZ/20` cycles (20 Hz) and a 50% duty cycle, overriding the duplex level. A collision burst on an idle indication starts lit at the next edge.
- R8: While `linkUp` is low, all three LEDs are low, both hold timers are cleared and all strobes are ignored. After the link returns, no blink appears until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency `CLK_HZ` |
| rstN | input | 1 | Active-low synchronous reset |
| linkUp | input | 1 | Link established (level) |
| speed100 | input | 1 | 1 = 100 Mbit/s, 0 = 10 Mbit/s (level) |
| fullDuplex | input | 1 | 1 = full-duplex operation (level) |
| txPulse | input | 1 | One-cycle strobe per transmitted frame |
| rxPulse | input | 1 | One-cycle strobe per received frame |
| colPulse | input | 1 | One-cycle strobe per collision |
| ledLinkSpd | output | 1 | Link-at-10-Mbit/s LED drive |
| ledAct | output | 1 | Activity blink LED drive |
| ledDupCol | output | 1 | Duplex steady / collision blink LED drive |

## Verification
Two things can land in the same clock cycle: a transmit strobe and a collision strobe. They compete for the activity indication, and the collision strobe must win. The bench raises `txPulse` and `colPulse` together while the activity indication is idle. It then requires `ledAct` to stay dark for many cycles, and it requires `ledDupCol` to start its collision blink at the very next edge. A second overlap is the collision blink running on top of a full-duplex link. This is judged by measuring the dark half-periods of `ledDupCol` and the edge-to-edge blink period while `fullDuplex` stays high.

// File: rtl/ethLedPkg.sv
package ethLedPkg;
  // strobes issued by the control to the blink datapath each cycle
  typedef struct packed {
    logic actTrig;   // accepted tx/rx activity
    logic colTrig;   // accepted collision
    logic clearAll;  // link down: wipe holds and phases
  } ledStrobes_t;

  // one prescaler tick is 1/40 s (25 ms)
  localparam int unsigned TICKS_PER_SEC  = 40;
  // half-period lengths in ticks: 50 ms for 10 Hz, 25 ms for 20 Hz
  localparam int unsigned ACT_HALF_TICKS = 2;
  localparam int unsigned COL_HALF_TICKS = 1;
  // hold length as a divisor of the clock rate (1/10 s)
  localparam int unsigned HOLD_DIV       = 10;
endpackage

// File: rtl/ledTickGen.sv
module ledTickGen #(
  parameter int unsigned TICK_CYC = 100
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int unsigned CNT_W = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYC - 1);

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (divCnt == CNT_LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick = (divCnt == CNT_LAST);
endmodule

// File: rtl/ledBlinkChannel.sv
module ledBlinkChannel #(
  parameter int unsigned HOLD_CYC   = 400,
  parameter int unsigned HALF_TICKS = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic trig,
  input  logic clear,
  input  logic tick,
  output logic live,
  output logic lit
);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int unsigned TC_W   = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC);
  localparam logic [TC_W-1:0]   TC_LAST   = TC_W'(HALF_TICKS - 1);

  logic [HOLD_W-1:0] holdCnt;
  logic [TC_W-1:0]   tickCnt;
  logic              phaseOn;
  logic              idle;

  assign idle = (holdCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      holdCnt <= '0;
      tickCnt <= '0;
      phaseOn <= 1'b0;
    end else begin
      // retriggerable hold
      if (trig) begin
        holdCnt <= HOLD_LOAD;
      end else if (!idle) begin
        holdCnt <= holdCnt - 1'b1;
      end
      // phase: fresh burst starts lit, otherwise follow the shared tick
      if (trig && idle) begin
        phaseOn <= 1'b1;
        tickCnt <= '0;
      end else if (tick) begin
        if (tickCnt == TC_LAST) begin
          tickCnt <= '0;
          phaseOn <= ~phaseOn;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  assign live = !idle;
  assign lit  = !idle && phaseOn;
endmodule

// File: rtl/ledBlinkPath.sv
module ledBlinkPath
  import ethLedPkg::*;
#(
  parameter int unsigned CLK_HZ = 25_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ledStrobes_t stb,
  output logic        actLive,
  output logic        actLit,
  output logic        colLive,
  output logic        colLit
);
  localparam int unsigned TICK_CYC = CLK_HZ / TICKS_PER_SEC;
  localparam int unsigned HOLD_CYC = CLK_HZ / HOLD_DIV;
  localparam int unsigned N_CH     = 2;

  logic            tick;
  logic [N_CH-1:0] trigV;
  logic [N_CH-1:0] liveV;
  logic [N_CH-1:0] litV;

  ledTickGen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  // channel 0: activity, channel 1: collision
  assign trigV = {stb.colTrig, stb.actTrig};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam int unsigned HALF = (ch == 0) ? ACT_HALF_TICKS : COL_HALF_TICKS;
    ledBlinkChannel #(
      .HOLD_CYC   (HOLD_CYC),
      .HALF_TICKS (HALF)
    ) u_chan (
      .clk   (clk),
      .rstN  (rstN),
      .trig  (trigV[ch]),
      .clear (stb.clearAll),
      .tick  (tick),
      .live  (liveV[ch]),
      .lit   (litV[ch])
    );
  end

  assign actLive = liveV[0];
  assign actLit  = litV[0];
  assign colLive = liveV[1];
  assign colLit  = litV[1];
endmodule

// File: rtl/ledCtrl.sv
module ledCtrl
  import ethLedPkg::*;
(
  input  logic        linkUp,
  input  logic        speed100,
  input  logic        fullDuplex,
  input  logic        txPulse,
  input  logic        rxPulse,
  input  logic        colPulse,
  input  logic        actLit,
  input  logic        colLive,
  input  logic        colLit,
  output ledStrobes_t stb,
  output logic        ledLinkSpd,
  output logic        ledAct,
  output logic        ledDupCol
);
  always_comb begin
    // collision wins over a coincident frame strobe
    stb.actTrig  = linkUp && (txPulse || rxPulse) && !colPulse;
    stb.colTrig  = linkUp && colPulse;
    stb.clearAll = !linkUp;
  end

  always_comb begin
    ledLinkSpd = linkUp && !speed100;
    ledAct     = linkUp && actLit;
    if (!linkUp) begin
      ledDupCol = 1'b0;
    end else if (colLive) begin
      ledDupCol = colLit;
    end else begin
      ledDupCol = fullDuplex;
    end
  end
endmodule

// File: rtl/ethLedDriver.sv
module ethLedDriver
  import ethLedPkg::*;
#(
  parameter int unsigned CLK_HZ = 25_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic linkUp,
  input  logic speed100,
  input  logic fullDuplex,
  input  logic txPulse,
  input  logic rxPulse,
  input  logic colPulse,
  output logic ledLinkSpd,
  output logic ledAct,
  output logic ledDupCol
);
  ledStrobes_t stb;
  logic actLive;
  logic actLit;
  logic colLive;
  logic colLit;

  ledCtrl u_ctrl (
    .linkUp     (linkUp),
    .speed100   (speed100),
    .fullDuplex (fullDuplex),
    .txPulse    (txPulse),
    .rxPulse    (rxPulse),
    .colPulse   (colPulse),
    .actLit     (actLit),
    .colLive    (colLive),
    .colLit     (colLit),
    .stb        (stb),
    .ledLinkSpd (ledLinkSpd),
    .ledAct     (ledAct),
    .ledDupCol  (ledDupCol)
  );

  ledBlinkPath #(.CLK_HZ(CLK_HZ)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .actLive (actLive),
    .actLit  (actLit),
    .colLive (colLive),
    .colLit  (colLit)
  );
endmodule

// File: rtl/ethLedChecker.sv
module ethLedChecker (
  input logic clk,
  input logic rstN,
  input logic linkUp,
  input logic speed100,
  input logic fullDuplex,
  input logic txPulse,
  input logic rxPulse,
  input logic colPulse,
  input logic ledLinkSpd,
  input logic ledAct,
  input logic ledDupCol,
  input logic actLive,
  input logic colLive
);
  // R8
  link_down_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |-> (!ledLinkSpd && !ledAct && !ledDupCol));

  // R1
  slow_link_lit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp && !speed100) |-> ledLinkSpd);

  // R2
  act_start_lit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp && !actLive && (txPulse || rxPulse) && !colPulse) |=> (ledAct || !linkUp));

  // R4
  act_idle_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !actLive |-> !ledAct);

  // R5
  col_no_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!actLive && colPulse) |=> !actLive);

  // R6
  duplex_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp && fullDuplex && !colLive) |-> ledDupCol);

  // R7
  col_start_lit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp && colPulse && !colLive) |=> (ledDupCol || !linkUp));
endmodule

bind ethLedDriver ethLedChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .linkUp     (linkUp),
  .speed100   (speed100),
  .fullDuplex (fullDuplex),
  .txPulse    (txPulse),
  .rxPulse    (rxPulse),
  .colPulse   (colPulse),
  .ledLinkSpd (ledLinkSpd),
  .ledAct     (ledAct),
  .ledDupCol  (ledDupCol),
  .actLive    (actLive),
  .colLive    (colLive)
);

// File: tb/sim_ethLedDriver.sv
module sim_ethLedDriver;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4000;
  localparam int HOLD       = CLK_HZ / 10;  // 400 cycles
  localparam int ACT_PER    = CLK_HZ / 10;  // 400 cycles
  localparam int COL_PER    = CLK_HZ / 20;  // 200 cycles

  logic clk = 1'b0;
  logic rstN, linkUp, speed100, fullDuplex, txPulse, rxPulse, colPulse;
  logic ledLinkSpd, ledAct, ledDupCol;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ethLedDriver #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .speed100(speed100),
    .fullDuplex(fullDuplex), .txPulse(txPulse), .rxPulse(rxPulse),
    .colPulse(colPulse), .ledLinkSpd(ledLinkSpd), .ledAct(ledAct),
    .ledDupCol(ledDupCol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input bit tx, input bit rx, input bit col);
    @(negedge clk);
    txPulse = tx; rxPulse = rx; colPulse = col;
    @(negedge clk);
    txPulse = 0; rxPulse = 0; colPulse = 0;
  endtask

  task automatic t_reset;
    rstN = 0; linkUp = 0; speed100 = 0; fullDuplex = 0;
    txPulse = 0; rxPulse = 0; colPulse = 0;
    waitN(4);
    rstN = 1;
    waitN(2);
    check(ledLinkSpd == 0 && ledAct == 0 && ledDupCol == 0, "R8 reset dark",
          {ledLinkSpd, ledAct, ledDupCol}, 0);
  endtask

  task automatic t_linkSpeed;
    linkUp = 1; speed100 = 0;
    waitN(1);
    check(ledLinkSpd == 1, "R1 10M link lit", ledLinkSpd, 1);
    speed100 = 1;
    waitN(1);
    check(ledLinkSpd == 0, "R1 100M link dark", ledLinkSpd, 0);
    speed100 = 0;
    waitN(1);
  endtask

  task automatic t_duplexSteady;
    int lows = 0;
    fullDuplex = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!ledDupCol) lows++;
    end
    check(lows == 0, "R6 duplex steady lit", lows, 0);
    fullDuplex = 0;
    waitN(1);
    check(ledDupCol == 0, "R6 half duplex dark", ledDupCol, 0);
  endtask

  task automatic t_actStart;
    strobe(0, 1, 0);
    check(ledAct == 1, "R2 rx burst starts lit", ledAct, 1);
    waitN(HOLD);
    check(ledAct == 0, "R4 hold expired", ledAct, 0);
    strobe(1, 0, 0);
    check(ledAct == 1, "R2 tx burst starts lit", ledAct, 1);
    waitN(HOLD + 1);
  endtask

  task automatic t_actPeriod;
    int rise[$];
    int fallAfter = -1;
    bit prev = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      txPulse = (i % 50 == 0);
      if (ledAct && !prev) rise.push_back(cyc);
      if (!ledAct && prev && rise.size() == 2 && fallAfter < 0) fallAfter = cyc;
      prev = ledAct;
    end
    txPulse = 0;
    check(rise.size() >= 4, "R4 retrigger keeps blinking", rise.size(), 4);
    if (rise.size() >= 3) begin
      check(rise[2] - rise[1] == ACT_PER, "R3 activity period", rise[2] - rise[1], ACT_PER);
      check(fallAfter - rise[1] == ACT_PER / 2, "R3 activity duty", fallAfter - rise[1], ACT_PER / 2);
    end
    waitN(HOLD + 2);
    check(ledAct == 0, "R4 dark after last strobe", ledAct, 0);
  endtask

  task automatic t_collision;
    int rise[$];
    int fallAfter = -1;
    int actHigh = 0;
    int dupLow = 0;
    bit prev = 1;
    fullDuplex = 1;
    waitN(1);
    strobe(0, 0, 1);
    check(ledDupCol == 1 && ledAct == 0, "R7 collision burst starts lit, R5 no activity",
          {ledDupCol, ledAct}, 2);
    prev = ledDupCol;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      colPulse = (i % 50 == 0);
      if (ledAct) actHigh++;
      if (!ledDupCol) dupLow++;
      if (ledDupCol && !prev) rise.push_back(cyc);
      if (!ledDupCol && prev && rise.size() == 2 && fallAfter < 0) fallAfter = cyc;
      prev = ledDupCol;
    end
    colPulse = 0;
    check(actHigh == 0, "R5 collisions leave activity dark", actHigh, 0);
    check(dupLow > 0, "R7 collision blink overrides duplex", dupLow, 1);
    if (rise.size() >= 3) begin
      check(rise[2] - rise[1] == COL_PER, "R7 collision period", rise[2] - rise[1], COL_PER);
      check(fallAfter - rise[1] == COL_PER / 2, "R7 collision duty", fallAfter - rise[1], COL_PER / 2);
    end else begin
      check(0, "R7 collision blink edges", rise.size(), 3);
    end
    waitN(HOLD + 2);
    check(ledDupCol == 1, "R6 duplex steady after collision hold", ledDupCol, 1);
    fullDuplex = 0;
    waitN(HOLD);
  endtask

  task automatic t_sameCycle;
    int actHigh = 0;
    strobe(1, 0, 1);
    check(ledAct == 0, "R5 tx with collision rejected", ledAct, 0);
    check(ledDupCol == 1, "R7 coincident collision lit", ledDupCol, 1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ledAct) actHigh++;
    end
    check(actHigh == 0, "R5 activity stays dark", actHigh, 0);
    waitN(HOLD);
  endtask

  task automatic t_linkDrop;
    strobe(0, 1, 0);
    check(ledAct == 1, "R2 burst before link drop", ledAct, 1);
    fullDuplex = 1;
    linkUp = 0;
    waitN(1);
    check(ledLinkSpd == 0 && ledAct == 0 && ledDupCol == 0, "R8 link down dark",
          {ledLinkSpd, ledAct, ledDupCol}, 0);
    strobe(1, 1, 1);
    check(ledAct == 0 && ledDupCol == 0, "R8 strobes ignored while down", {ledAct, ledDupCol}, 0);
    fullDuplex = 0; speed100 = 1;
    linkUp = 1;
    waitN(3);
    check(ledAct == 0, "R8 activity hold cleared", ledAct, 0);
    check(ledDupCol == 0, "R8 collision hold cleared", ledDupCol, 0);
  endtask

  initial begin
    t_reset;
    t_linkSpeed;
    t_duplexSteady;
    t_actStart;
    t_actPeriod;
    t_collision;
    t_sameCycle;
    t_linkDrop;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule